// File: doc/BRIEF.md
# Programmable Multifunction Timing Channel

This block is one channel of a timing unit. After configuration and an arm command, it waits for a start condition. The start can come from one of three sources: a decoded 8-bit event code from the facility timing link that matches a programmed value, a rising edge on an external input, or a software strobe. Once started, the channel runs one of four behaviours: a delayed single-tick trigger, a delayed gate of programmed width, a delayed free-running clock, or counting pulses on the external input.

All delay, width and half-period timing advances on a 10 MHz tick enable, which gives 100 ns resolution. Software writes a shadow register set at any time. The channel copies that set into its working configuration only when it is armed, so writes made while a run is pending or in progress do not affect that run. The channel drives one output and reports busy, done and a sticky overrun flag.

Top module: `tmg_channel`

## Requirements
- R1: After reset, chan_out, busy, done and overrun are 0, pulse_count is 0, and the channel is idle.
- R2: Register writes go to a shadow set and reach the working configuration only when cmd_arm is accepted. The address map is: 0 = control, with mode in bits [1:0] and source in bits [3:2]; 1 = event code in bits [7:0]; 2 = delay; 3 = width; 4 = half-period; 5 = count target. A write made after arming has no effect until the next arm.
- R3: The source encoding is 0 = link event (evt_valid high and evt_code equal to the programmed code), 1 = rising edge of ext_in, 2 = sw_strobe, 3 = never start. A start is taken only while the channel is armed. A level held on ext_in is not a start.
- R4: Mode 0 (trigger): after a start with delay D, chan_out rises on the (D+1)-th tick after the start. It stays high for exactly one tick, and the channel then shows done. The width register is ignored in this mode.
- R5: Mode 1 (gate): after a delay of D ticks, chan_out is high for W ticks, with a W of 0 treated as 1. The channel then shows done.
- R6: Mode 2 (clock): after a delay of D ticks, chan_out rises and then toggles every P ticks, with a P of 0 treated as 1. It keeps running with busy high until a disarm, and never shows done.
- R7: Mode 3 (count): while armed, each rising edge of ext_in adds one to pulse_count, which saturates at its all-ones value. chan_out is high when the count target is nonzero and pulse_count is at least the target. A software strobe does not start this mode. An accepted arm clears pulse_count.
- R8: A start condition that arrives while the channel is in its delay or active phase is ignored and sets overrun. Overrun stays set until the next accepted arm.
- R9: cmd_disarm returns the channel to idle from any state on the next clock, with chan_out low. It takes priority over cmd_arm in the same cycle.
- R10: busy is high exactly in the delay and active phases, and done is high only after a completed trigger or gate. The two are never high together.
- R11: Delay, width and half-period counting advance only on clocks where tick_en is high. Without ticks, a started channel stays busy with its output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-clock enable at 10 MHz, the timing resolution |
| cfg_we | input | 1 | Shadow register write strobe |
| cfg_addr | input | 3 | Shadow register address |
| cfg_wdata | input | 32 | Shadow register write data |
| cmd_arm | input | 1 | Load the working configuration and wait for a start |
| cmd_disarm | input | 1 | Return to idle |
| sw_strobe | input | 1 | Software start command |
| evt_valid | input | 1 | Decoded link event strobe |
| evt_code | input | 8 | Decoded link event code |
| ext_in | input | 1 | External input, synchronous to clk |
| chan_out | output | 1 | Channel timing output |
| busy | output | 1 | Delay or active phase in progress |
| done | output | 1 | Trigger or gate completed |
| overrun | output | 1 | Sticky flag for a start that arrived while busy |
| pulse_count | output | CNT_W | Count of external rising edges in count mode |

## Verification
Trigger, gate and clock runs are tried with random delays, widths and half-periods, including zeros. The tick-by-tick output is compared against a computed waveform, which separates an off-by-one in the delay from one in the width or toggle spacing. Each start source is driven with a matching stimulus and with near misses: a wrong event code, a valid-low match, a held external level, and a strobe with the source disabled. These show that only the selected qualified condition starts the channel. Directed runs cover a start that arrives mid-run, a configuration rewrite while armed, a stalled tick enable and counter saturation.

// File: rtl/tmg_pkg.sv
// Shared types for the timing channel: mode and source codes, sequencer
// states, register addresses and the configuration record.
package tmg_pkg;
    localparam int TMG_DW = 32;   // width of timing and target fields
    localparam int TMG_EW = 8;    // event code width
    localparam int TMG_AW = 3;    // register address width

    typedef enum logic [1:0] {
        MODE_TRIG = 2'd0,
        MODE_GATE = 2'd1,
        MODE_CLK  = 2'd2,
        MODE_CNT  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SRC_LINK = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_SW   = 2'd2,
        SRC_OFF  = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_DELAY  = 3'd2,
        ST_ACTIVE = 3'd3,
        ST_DONE   = 3'd4
    } state_e;

    localparam logic [TMG_AW-1:0] A_CTRL   = 3'd0;
    localparam logic [TMG_AW-1:0] A_CODE   = 3'd1;
    localparam logic [TMG_AW-1:0] A_DELAY  = 3'd2;
    localparam logic [TMG_AW-1:0] A_WIDTH  = 3'd3;
    localparam logic [TMG_AW-1:0] A_HALF   = 3'd4;
    localparam logic [TMG_AW-1:0] A_TARGET = 3'd5;

    typedef struct packed {
        mode_e              mode;
        src_e               src;
        logic [TMG_EW-1:0]  code;
        logic [TMG_DW-1:0]  delay;
        logic [TMG_DW-1:0]  width;
        logic [TMG_DW-1:0]  half;
        logic [TMG_DW-1:0]  target;
    } cfg_t;
endpackage

// File: rtl/tmg_cfg_regs.sv
// Shadow register set plus working copy. Software writes the shadow set at
// any time. The working copy is loaded from the shadow set when an arm is
// accepted. Assumes writes and arm are single-cycle strobes.
module tmg_cfg_regs
    import tmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [TMG_AW-1:0] cfg_addr,
    input  logic [TMG_DW-1:0] cfg_wdata,
    input  logic              arm_take,
    output cfg_t              live_cfg
);
    cfg_t shadow;

    // Shadow register writes by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                A_CTRL: begin
                    shadow.mode <= mode_e'(cfg_wdata[1:0]);
                    shadow.src  <= src_e'(cfg_wdata[3:2]);
                end
                A_CODE:   shadow.code   <= cfg_wdata[TMG_EW-1:0];
                A_DELAY:  shadow.delay  <= cfg_wdata;
                A_WIDTH:  shadow.width  <= cfg_wdata;
                A_HALF:   shadow.half   <= cfg_wdata;
                A_TARGET: shadow.target <= cfg_wdata;
                default: ;
            endcase
        end
    end

    // Working copy loaded on an accepted arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_cfg <= '0;
        end else if (arm_take) begin
            live_cfg <= shadow;
        end
    end
endmodule

// File: rtl/tmg_start_sel.sv
// Start condition selection. Qualifies a link event match, an external
// rising edge or a software strobe according to the configured source.
// Assumes ext_in is already synchronous to clk.
module tmg_start_sel
    import tmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  src_e              src,
    input  logic [TMG_EW-1:0] code,
    input  logic              evt_valid,
    input  logic [TMG_EW-1:0] evt_code,
    input  logic              ext_in,
    input  logic              sw_strobe,
    output logic              start,
    output logic              ext_rise
);
    logic ext_prev;

    // Previous external level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_in;
    end

    assign ext_rise = ext_in & ~ext_prev;

    // Source multiplexer.
    always_comb begin
        case (src)
            SRC_LINK: start = evt_valid && (evt_code == code);
            SRC_EXT:  start = ext_rise;
            SRC_SW:   start = sw_strobe;
            default:  start = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmg_pulse_cnt.sv
// Saturating counter of external rising edges, cleared on an accepted arm.
// Counts only while enabled by the sequencer (armed in count mode).
module tmg_pulse_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             ext_rise,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    // Clear, count or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (enable && ext_rise && (count != CMAX)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/tmg_seq.sv
// Channel sequencer: idle, armed, delay, active, done. Times the delay,
// width and half-period in ticks, drives the registered output and keeps
// the sticky overrun flag. Disarm has priority over arm.
module tmg_seq
    import tmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              arm_take,
    input  logic              disarm,
    input  logic              start,
    input  logic              reached,
    input  mode_e             mode,
    input  logic [TMG_DW-1:0] delay,
    input  logic [TMG_DW-1:0] width,
    input  logic [TMG_DW-1:0] half,
    output state_e            state,
    output logic              out_q,
    output logic              overrun
);
    logic [TMG_DW-1:0] tmr;
    logic [TMG_DW-1:0] width_ld;
    logic [TMG_DW-1:0] half_ld;
    logic [TMG_DW-1:0] active_ld;

    // Reload values; a zero width or half-period acts as one tick.
    always_comb begin
        width_ld = (width == '0) ? '0 : width - 1'b1;
        half_ld  = (half  == '0) ? '0 : half  - 1'b1;
        case (mode)
            MODE_GATE: active_ld = width_ld;
            MODE_CLK:  active_ld = half_ld;
            default:   active_ld = '0;
        endcase
    end

    // State, timer, output and overrun update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tmr     <= '0;
            out_q   <= 1'b0;
            overrun <= 1'b0;
        end else if (disarm) begin
            state <= ST_IDLE;
            out_q <= 1'b0;
        end else if (arm_take) begin
            state   <= ST_ARMED;
            out_q   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            case (state)
                ST_ARMED: begin
                    if (mode == MODE_CNT) begin
                        out_q <= reached;
                    end else if (start) begin
                        state <= ST_DELAY;
                        tmr   <= delay;
                    end
                end
                ST_DELAY: begin
                    if (start) overrun <= 1'b1;
                    if (tick_en) begin
                        if (tmr == '0) begin
                            state <= ST_ACTIVE;
                            out_q <= 1'b1;
                            tmr   <= active_ld;
                        end else begin
                            tmr <= tmr - 1'b1;
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (start) overrun <= 1'b1;
                    if (tick_en) begin
                        if (tmr != '0) begin
                            tmr <= tmr - 1'b1;
                        end else if (mode == MODE_CLK) begin
                            out_q <= ~out_q;
                            tmr   <= half_ld;
                        end else begin
                            state <= ST_DONE;
                            out_q <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tmg_channel.sv
// Top of one programmable timing channel. Connects the register set, the
// start selector, the pulse counter and the sequencer. Assumes tick_en is
// a one-clock pulse at the timing resolution and CNT_W <= 32.
module tmg_channel
    import tmg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cfg_we,
    input  logic [TMG_AW-1:0] cfg_addr,
    input  logic [TMG_DW-1:0] cfg_wdata,
    input  logic              cmd_arm,
    input  logic              cmd_disarm,
    input  logic              sw_strobe,
    input  logic              evt_valid,
    input  logic [TMG_EW-1:0] evt_code,
    input  logic              ext_in,
    output logic              chan_out,
    output logic              busy,
    output logic              done,
    output logic              overrun,
    output logic [CNT_W-1:0]  pulse_count
);
    cfg_t              live_cfg;
    state_e            state;
    logic              arm_take;
    logic              start;
    logic              ext_rise;
    logic              reached;
    logic              cnt_en;
    logic [TMG_DW-1:0] cnt_ext;

    assign arm_take = cmd_arm & ~cmd_disarm;
    assign cnt_en   = (state == ST_ARMED) && (live_cfg.mode == MODE_CNT);
    assign cnt_ext  = TMG_DW'(pulse_count);
    assign reached  = (live_cfg.target != '0) && (cnt_ext >= live_cfg.target);

    tmg_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .arm_take  (arm_take),
        .live_cfg  (live_cfg)
    );

    tmg_start_sel u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (live_cfg.src),
        .code      (live_cfg.code),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .ext_in    (ext_in),
        .sw_strobe (sw_strobe),
        .start     (start),
        .ext_rise  (ext_rise)
    );

    tmg_pulse_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (arm_take),
        .enable   (cnt_en),
        .ext_rise (ext_rise),
        .count    (pulse_count)
    );

    tmg_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .arm_take (arm_take),
        .disarm   (cmd_disarm),
        .start    (start),
        .reached  (reached),
        .mode     (live_cfg.mode),
        .delay    (live_cfg.delay),
        .width    (live_cfg.width),
        .half     (live_cfg.half),
        .state    (state),
        .out_q    (chan_out),
        .overrun  (overrun)
    );

    assign busy = (state == ST_DELAY) || (state == ST_ACTIVE);
    assign done = (state == ST_DONE);
endmodule

// File: rtl/tmg_channel_chk.sv
// Property checker for tmg_channel, attached by bind. Observes ports plus
// the working mode field.
module tmg_channel_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             cmd_arm,
    input logic             cmd_disarm,
    input logic             chan_out,
    input logic             busy,
    input logic             done,
    input logic             overrun,
    input logic [CNT_W-1:0] pulse_count,
    input logic [1:0]       run_mode
);
    p_status_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !cmd_arm) |=> overrun);

    p_disarm_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disarm |=> (!busy && !done && !chan_out));

    p_count_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pulse_count == '1) && !cmd_arm) |=> (pulse_count == '1));

    p_count_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_arm |=> (pulse_count >= $past(pulse_count)));

    p_tick_paced_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cmd_arm && !cmd_disarm && (run_mode != 2'd3)) |=> $stable(chan_out));

    p_done_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(chan_out) && $past(tick_en)));
endmodule

bind tmg_channel tmg_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .cmd_arm     (cmd_arm),
    .cmd_disarm  (cmd_disarm),
    .chan_out    (chan_out),
    .busy        (busy),
    .done        (done),
    .overrun     (overrun),
    .pulse_count (pulse_count),
    .run_mode    (live_cfg.mode)
);

// File: tb/tb_tmg_channel.sv
// Self-checking bench for tmg_channel: directed corner cases plus seeded
// random trigger, gate and clock runs against computed waveforms.
module tb_tmg_channel;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_addr = '0;
    logic [31:0]      cfg_wdata = '0;
    logic             cmd_arm = 1'b0;
    logic             cmd_disarm = 1'b0;
    logic             sw_strobe = 1'b0;
    logic             evt_valid = 1'b0;
    logic [7:0]       evt_code = '0;
    logic             ext_in = 1'b0;
    logic             chan_out;
    logic             busy;
    logic             done;
    logic             overrun;
    logic [CNT_W-1:0] pulse_count;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    tmg_channel #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cmd_arm(cmd_arm),
        .cmd_disarm(cmd_disarm), .sw_strobe(sw_strobe), .evt_valid(evt_valid),
        .evt_code(evt_code), .ext_in(ext_in), .chan_out(chan_out), .busy(busy),
        .done(done), .overrun(overrun), .pulse_count(pulse_count)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clk1();
        @(posedge clk);
        #1;
    endtask

    task automatic do_tick();
        tick_en = 1'b1;
        clk1();
        tick_en = 1'b0;
        repeat (3) clk1();
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        clk1();
        cfg_we = 1'b0;
    endtask

    task automatic arm();
        cmd_arm = 1'b1; clk1(); cmd_arm = 1'b0;
    endtask

    task automatic disarm();
        cmd_disarm = 1'b1; clk1(); cmd_disarm = 1'b0;
    endtask

    task automatic strobe();
        sw_strobe = 1'b1; clk1(); sw_strobe = 1'b0;
    endtask

    task automatic ext_pulse();
        ext_in = 1'b1; clk1(); ext_in = 1'b0; clk1(); clk1();
    endtask

    task automatic setup(input int mode, input int src, input int d, input int w,
                         input int h, input int tgt);
        wr(3'd0, mode | (src << 2));
        wr(3'd2, d);
        wr(3'd3, w);
        wr(3'd4, h);
        wr(3'd5, tgt);
    endtask

    // Expected output level after tick j (1-based) following a start.
    function automatic int exp_out(int mode, int d, int w, int h, int j);
        int k, we, p;
        if (j < d + 1) return 0;
        k  = j - (d + 1);
        we = (w == 0) ? 1 : w;
        p  = (h == 0) ? 1 : h;
        case (mode)
            0: return (k < 1) ? 1 : 0;
            1: return (k < we) ? 1 : 0;
            default: return (((k / p) % 2) == 0) ? 1 : 0;
        endcase
    endfunction

    function automatic int exp_done(int mode, int d, int w, int j);
        int we;
        if (mode == 2) return 0;
        we = (mode == 0) ? 1 : ((w == 0) ? 1 : w);
        return (j >= d + 1 + we) ? 1 : 0;
    endfunction

    task automatic run_ticks(input int mode, input int d, input int w, input int h,
                             input int j0, input int j1, input string tag);
        for (int j = j0; j <= j1; j++) begin
            do_tick();
            check($sformatf("%s out tick %0d", tag, j), chan_out, exp_out(mode, d, w, h, j));
            check($sformatf("%s done tick %0d", tag, j), done, exp_done(mode, d, w, j));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int mode, d, w, h;
        void'($urandom(32'h5EED_0017));
        repeat (4) clk1();
        rst_n = 1'b1;
        clk1();

        // R1 reset state
        check("R1 out", chan_out, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 overrun", overrun, 0);
        check("R1 count", pulse_count, 0);

        // R4 trigger, width ignored, software source (R3)
        setup(0, 2, 3, 5, 0, 0);
        arm();
        strobe();
        check("R3 sw start busy", busy, 1);
        run_ticks(0, 3, 5, 0, 1, 7, "R4 trigger");

        // R11 no ticks: no progress
        arm();
        strobe();
        repeat (20) clk1();
        check("R11 busy held", busy, 1);
        check("R11 out held", chan_out, 0);
        disarm();
        check("R9 disarm busy", busy, 0);

        // R5 gate widths 3 and 0
        setup(1, 2, 0, 3, 0, 0);
        arm(); strobe();
        run_ticks(1, 0, 3, 0, 1, 6, "R5 gate w3");
        wr(3'd3, 0);
        arm(); strobe();
        run_ticks(1, 0, 0, 0, 1, 3, "R5 gate w0");

        // R6 clock, then R9 disarm while active
        setup(2, 2, 1, 0, 2, 0);
        arm(); strobe();
        run_ticks(2, 1, 0, 2, 1, 12, "R6 clock");
        check("R6 busy running", busy, 1);
        disarm();
        check("R9 out low", chan_out, 0);
        check("R9 busy low", busy, 0);

        // R3 link event source
        setup(0, 0, 0, 0, 0, 0);
        wr(3'd1, 32'h5A);
        arm();
        evt_valid = 1'b1; evt_code = 8'hA5; clk1(); evt_valid = 1'b0; clk1();
        check("R3 link wrong code", busy, 0);
        evt_code = 8'h5A; clk1(); clk1();
        check("R3 link valid low", busy, 0);
        evt_valid = 1'b1; clk1(); evt_valid = 1'b0;
        check("R3 link match", busy, 1);
        disarm();

        // R3 external edge vs held level
        setup(0, 1, 0, 0, 0, 0);
        arm();
        ext_in = 1'b1; clk1();
        check("R3 ext edge", busy, 1);
        disarm();
        arm();
        repeat (3) clk1();
        check("R3 ext level", busy, 0);
        ext_in = 1'b0; clk1();

        // R3 source disabled
        setup(0, 3, 0, 0, 0, 0);
        arm(); strobe(); clk1();
        check("R3 source off", busy, 0);

        // R8 overrun: second start ignored, flag sticky until arm
        setup(0, 2, 4, 0, 0, 0);
        arm(); strobe();
        run_ticks(0, 4, 0, 0, 1, 2, "R8 pre");
        strobe();
        check("R8 overrun set", overrun, 1);
        run_ticks(0, 4, 0, 0, 3, 7, "R8 timing kept");
        check("R8 overrun sticky", overrun, 1);
        arm();
        check("R8 overrun cleared", overrun, 0);

        // R2 shadow write while armed takes effect on next arm
        setup(0, 2, 0, 0, 0, 0);
        arm();
        wr(3'd2, 5);
        strobe();
        run_ticks(0, 0, 0, 0, 1, 2, "R2 old delay");
        arm(); strobe();
        run_ticks(0, 5, 0, 0, 1, 7, "R2 new delay");

        // R7 pulse counting, target, saturation, strobe ignored
        setup(3, 2, 0, 0, 0, 3);
        arm();
        strobe(); clk1();
        check("R7 strobe ignored", busy, 0);
        ext_pulse(); ext_pulse();
        check("R7 count 2", pulse_count, 2);
        check("R7 below target", chan_out, 0);
        ext_pulse();
        check("R7 count 3", pulse_count, 3);
        check("R7 target reached", chan_out, 1);
        for (int i = 0; i < 20; i++) ext_pulse();
        check("R7 saturated", pulse_count, 15);
        arm();
        check("R7 cleared on arm", pulse_count, 0);
        disarm();

        // Random trigger / gate / clock runs
        for (int it = 0; it < 15; it++) begin
            mode = $urandom_range(0, 2);
            d = $urandom_range(0, 5);
            w = $urandom_range(0, 4);
            h = $urandom_range(0, 4);
            setup(mode, 2, d, w, h, 0);
            arm(); strobe();
            run_ticks(mode, d, w, h, 1, d + 10,
                      $sformatf("R%0d random", (mode == 0) ? 4 : (mode == 1) ? 5 : 6));
            disarm();
        end

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule